// File: doc/BRIEF.md
# Receive ADC-to-Downconverter Input Crossbar

This block sits between a bank of ADC sample streams and a set of complex downconverter channels. Every channel has an in-phase (I) and a quadrature (Q) input. A 32-bit routing word picks which ADC feeds each of those inputs. The Q inputs can instead be tied to constant zero for real-only reception. That choice covers the whole block: either every Q input is zeroed or none is.

Software loads the routing word through a one-cycle write strobe. The block checks the word before accepting it. An accepted word waits in a pending register and goes live at the next sample strobe, so a sample is never split between two routings. A rejected word leaves the routing as it was and raises a sticky error flag. Outputs are registered. They change only on sample strobes and are marked by a valid pulse one cycle later.

Top module: `rx_adc_xbar`

## Requirements
- R1: After reset, out_i, out_q, out_vld and cfg_err are all zero. The live routing word is 0x10101010, which sends ADC0 to every I input and ADC1 to every Q input.
- R2: Channel c takes its I input from the ADC numbered by word bits [8c+3:8c]. Legal values are 0 to 3. The sample appears on out_i bits [16c+15:16c].
- R3: Channel c takes its Q input from the ADC numbered by word bits [8c+7:8c+4], on out_q bits [16c+15:16c]. A field value of 0xF drives that Q output with zero.
- R4: out_vld is high exactly in the cycle after a cycle with smp_stb high. In a cycle with smp_stb low, out_i and out_q keep their values into the next cycle.
- R5: A write is rejected if any I field is above 3, if any Q field is in the range 4 to 14, or if some Q fields are 0xF and others are not. A rejected write does not change the routing.
- R6: cfg_err goes high after a rejected write and goes low after a legal write. Cycles without a write leave it unchanged.
- R7: A legal word written in cycle N controls the first strobe sampled in cycle N+1 or later. A strobe in the same cycle as the write still uses the earlier routing.
- R8: When two legal writes arrive before a strobe, the later one is applied.
- R9: A rejected write that arrives while a legal word is pending does not cancel it. The pending word applies at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Routing word write strobe |
| cfg_wr_data | input | 32 | Routing word to write |
| smp_stb | input | 1 | Input sample strobe |
| adc_bus | input | 64 | Four 16-bit ADC samples; ADC k is at bits [16k+15:16k] |
| out_i | output | 64 | Registered I inputs of the four channels |
| out_q | output | 64 | Registered Q inputs of the four channels |
| out_vld | output | 1 | Marks the cycle in which out_i/out_q carry a new sample |
| cfg_err | output | 1 | Sticky flag set when a write is rejected |

## Verification
The bench sweeps I selections against every Q selection, including zero mode, with per-channel rotation. A design with swapped field positions, or one that ignored 0xF, would send the wrong ADC code to the output. It drives a write in the same cycle as a strobe. A design that applied the word early would show the new routing one sample too soon. It writes illegal words of each kind: an I field too large, a Q field in the gap from 4 to 14, and a mixed zero setting. A design that accepted any of these would change routing, or would not raise the error. It also checks that a rejected write does not cancel a pending legal one, and that a second legal write replaces the first.

// File: rtl/rx_xbar_pkg.sv
package rx_xbar_pkg;
    typedef enum logic [0:0] {
        CFG_IDLE = 1'b0,
        CFG_PEND = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/rx_xbar_cfg_check.sv
module rx_xbar_cfg_check #(
    parameter int NCH     = 4,
    parameter int NADC    = 4,
    parameter int FIELD_W = 4,
    localparam int CFG_W  = 2 * NCH * FIELD_W
) (
    input  logic [CFG_W-1:0] word,
    output logic             legal
);
    localparam logic [FIELD_W-1:0] ZERO_CODE = {FIELD_W{1'b1}};
    localparam logic [FIELD_W:0]   ADC_LIM   = (FIELD_W+1)'(NADC);

    logic [NCH-1:0] i_ok;
    logic [NCH-1:0] q_sel_ok;
    logic [NCH-1:0] q_zero;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [FIELD_W-1:0] i_fld;
        logic [FIELD_W-1:0] q_fld;
        assign i_fld       = word[2*FIELD_W*c +: FIELD_W];
        assign q_fld       = word[2*FIELD_W*c + FIELD_W +: FIELD_W];
        assign i_ok[c]     = {1'b0, i_fld} < ADC_LIM;
        assign q_zero[c]   = (q_fld == ZERO_CODE);
        assign q_sel_ok[c] = ({1'b0, q_fld} < ADC_LIM) || q_zero[c];
    end

    // Zero mode must be uniform across all channels
    assign legal = (&i_ok) && (&q_sel_ok) && ((&q_zero) || !(|q_zero));
endmodule

// File: rtl/rx_xbar_ctrl.sv
module rx_xbar_ctrl
    import rx_xbar_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int FIELD_W = 4,
    localparam int CFG_W  = 2 * NCH * FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             wr_legal,
    input  logic             smp_stb,
    output logic [CFG_W-1:0] eff_word,
    output logic             pend,
    output logic             err
);
    function automatic logic [CFG_W-1:0] rst_word_f();
        logic [CFG_W-1:0] w;
        w = '0;
        for (int c = 0; c < NCH; c++) begin
            w[2*FIELD_W*c + FIELD_W +: FIELD_W] = FIELD_W'(1);
        end
        return w;
    endfunction

    localparam logic [CFG_W-1:0] RST_WORD = rst_word_f();

    cfg_state_e       state, state_nxt;
    logic [CFG_W-1:0] act_word;
    logic [CFG_W-1:0] pend_word;
    logic             accept;

    assign accept = wr_en && wr_legal;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            CFG_IDLE: if (accept)       state_nxt = CFG_PEND;  // IDLE->PEND on legal write
            CFG_PEND: if (accept)       state_nxt = CFG_PEND;  // PEND->PEND replace
                      else if (smp_stb) state_nxt = CFG_IDLE;  // PEND->IDLE apply
            default:                    state_nxt = CFG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CFG_IDLE;
        else        state <= state_nxt;
    end

    // Word and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_word  <= RST_WORD;
            pend_word <= RST_WORD;
            err       <= 1'b0;
        end else begin
            if (state == CFG_PEND && smp_stb) act_word <= pend_word;
            if (accept)                       pend_word <= wr_data;
            if (wr_en)                        err <= !wr_legal;
        end
    end

    // Outputs
    always_comb begin
        pend     = (state == CFG_PEND);
        eff_word = pend ? pend_word : act_word;
    end
endmodule

// File: rtl/rx_xbar_lane.sv
module rx_xbar_lane #(
    parameter int NADC    = 4,
    parameter int SMP_W   = 16,
    parameter int FIELD_W = 4,
    localparam int BUS_W  = NADC * SMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_stb,
    input  logic [BUS_W-1:0]   adc_bus,
    input  logic [FIELD_W-1:0] i_fld,
    input  logic [FIELD_W-1:0] q_fld,
    output logic [SMP_W-1:0]   i_out,
    output logic [SMP_W-1:0]   q_out
);
    logic [SMP_W-1:0] i_nxt, q_nxt;

    // Codes with no ADC behind them (zero code) select nothing
    always_comb begin
        i_nxt = '0;
        q_nxt = '0;
        for (int k = 0; k < NADC; k++) begin
            if (i_fld == FIELD_W'(k)) i_nxt = adc_bus[k*SMP_W +: SMP_W];
            if (q_fld == FIELD_W'(k)) q_nxt = adc_bus[k*SMP_W +: SMP_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_out <= '0;
            q_out <= '0;
        end else if (smp_stb) begin
            i_out <= i_nxt;
            q_out <= q_nxt;
        end
    end
endmodule

// File: rtl/rx_adc_xbar.sv
module rx_adc_xbar #(
    parameter int NCH     = 4,
    parameter int NADC    = 4,
    parameter int SMP_W   = 16,
    parameter int FIELD_W = 4,
    localparam int CFG_W  = 2 * NCH * FIELD_W,
    localparam int BUS_W  = NADC * SMP_W,
    localparam int OUT_W  = NCH * SMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    input  logic             smp_stb,
    input  logic [BUS_W-1:0] adc_bus,
    output logic [OUT_W-1:0] out_i,
    output logic [OUT_W-1:0] out_q,
    output logic             out_vld,
    output logic             cfg_err
);
    logic             legal_w;
    logic             pend_w;
    logic [CFG_W-1:0] eff_word;

    rx_xbar_cfg_check #(.NCH(NCH), .NADC(NADC), .FIELD_W(FIELD_W)) chk_u (
        .word  (cfg_wr_data),
        .legal (legal_w)
    );

    rx_xbar_ctrl #(.NCH(NCH), .FIELD_W(FIELD_W)) ctrl_u (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .wr_legal (legal_w),
        .smp_stb  (smp_stb),
        .eff_word (eff_word),
        .pend     (pend_w),
        .err      (cfg_err)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        rx_xbar_lane #(.NADC(NADC), .SMP_W(SMP_W), .FIELD_W(FIELD_W)) lane_u (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_stb (smp_stb),
            .adc_bus (adc_bus),
            .i_fld   (eff_word[2*FIELD_W*c +: FIELD_W]),
            .q_fld   (eff_word[2*FIELD_W*c + FIELD_W +: FIELD_W]),
            .i_out   (out_i[c*SMP_W +: SMP_W]),
            .q_out   (out_q[c*SMP_W +: SMP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= smp_stb;
    end
endmodule

// File: rtl/rx_adc_xbar_chk.sv
module rx_adc_xbar_chk #(
    parameter int OUT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic             smp_stb,
    input logic             cfg_legal,
    input logic             pend,
    input logic             cfg_err,
    input logic             out_vld,
    input logic [OUT_W-1:0] out_i,
    input logic [OUT_W-1:0] out_q
);
    a_r4_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> out_vld);
    a_r4_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> !out_vld);
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(out_i) && $stable(out_q)));
    a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_legal) |=> cfg_err);
    a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_legal) |=> !cfg_err);
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(cfg_err));
    a_r7_pend_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && smp_stb && !(cfg_wr_en && cfg_legal)) |=> !pend);
    a_r5_reject_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && cfg_wr_en && !cfg_legal) |=> !pend);
    a_r9_reject_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !smp_stb && cfg_wr_en && !cfg_legal) |=> pend);
endmodule

bind rx_adc_xbar rx_adc_xbar_chk #(.OUT_W(OUT_W)) chk_bind_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .smp_stb   (smp_stb),
    .cfg_legal (legal_w),
    .pend      (pend_w),
    .cfg_err   (cfg_err),
    .out_vld   (out_vld),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/rx_adc_xbar_tb_top.sv
`timescale 1ns/1ps
module rx_adc_xbar_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        smp_stb = 1'b0;
    logic [63:0] adc_bus = '0;
    logic [63:0] out_i, out_q;
    logic        out_vld, cfg_err;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [31:0] m_act  = 32'h1010_1010;
    logic [31:0] m_pw   = '0;
    bit          m_pv   = 0;
    bit          m_err  = 0;
    logic [63:0] last_i = '0;
    logic [63:0] last_q = '0;
    int          smp_n  = 0;

    always #2.5 clk = ~clk;

    rx_adc_xbar dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .smp_stb(smp_stb), .adc_bus(adc_bus), .out_i(out_i), .out_q(out_q),
        .out_vld(out_vld), .cfg_err(cfg_err)
    );

    function automatic logic [15:0] adc_val(int k, int n);
        return 16'((k + 1) * 16'h1000 + (n & 16'h0fff));
    endfunction

    function automatic bit legal_w(logic [31:0] w);
        int nz = 0;
        for (int c = 0; c < 4; c++) begin
            if (w[8*c +: 4] > 4'd3) return 0;
            if (w[8*c+4 +: 4] == 4'hF) nz++;
            else if (w[8*c+4 +: 4] > 4'd3) return 0;
        end
        return (nz == 0) || (nz == 4);
    endfunction

    function automatic logic [63:0] exp_bus(logic [31:0] w, bit isq, int n);
        logic [63:0] b = '0;
        for (int c = 0; c < 4; c++) begin
            logic [3:0] f = isq ? w[8*c+4 +: 4] : w[8*c +: 4];
            b[16*c +: 16] = (f == 4'hF) ? 16'h0 : adc_val(int'(f), n);
        end
        return b;
    endfunction

    task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One driven cycle; stb/wr chosen by caller; outputs checked a cycle later
    task automatic step(bit stb, bit wr, logic [31:0] w, string tag);
        logic [31:0] used;
        @(negedge clk);
        chk64("R4 idle vld", {63'd0, out_vld}, 64'd0);
        chk64("R4 hold i", out_i, last_i);
        chk64("R4 hold q", out_q, last_q);
        smp_n++;
        for (int k = 0; k < 4; k++) adc_bus[16*k +: 16] = adc_val(k, smp_n);
        smp_stb     = stb;
        cfg_wr_en   = wr;
        cfg_wr_data = w;
        used = m_pv ? m_pw : m_act;
        @(posedge clk);
        if (stb && m_pv) begin m_act = m_pw; m_pv = 0; end
        if (wr) begin
            m_err = !legal_w(w);
            if (legal_w(w)) begin m_pw = w; m_pv = 1; end
        end
        @(negedge clk);
        smp_stb   = 1'b0;
        cfg_wr_en = 1'b0;
        chk64({tag, " R4 vld"}, {63'd0, out_vld}, {63'd0, stb});
        chk64({tag, " R6 err"}, {63'd0, cfg_err}, {63'd0, m_err});
        if (stb) begin
            last_i = exp_bus(used, 0, smp_n);
            last_q = exp_bus(used, 1, smp_n);
            chk64({tag, " I"}, out_i, last_i);
            chk64({tag, " Q"}, out_q, last_q);
        end
    endtask

    function automatic logic [31:0] sweep_word(int a, int b);
        logic [31:0] w = '0;
        for (int c = 0; c < 4; c++) begin
            w[8*c +: 4]   = 4'((a + c) % 4);
            w[8*c+4 +: 4] = (b == 4) ? 4'hF : 4'((b + c + 1) % 4);
        end
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk64("R1 out_i", out_i, '0);
        chk64("R1 out_q", out_q, '0);
        chk64("R1 vld/err", {62'd0, out_vld, cfg_err}, '0);
        step(1, 0, '0, "R1 default routing");

        // R2 R3 sweep of I and Q selections including zero mode
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 5; b++) begin
                step(0, 1, sweep_word(a, b), "R2 R3 write");
                step(1, 0, '0, "R2 R3 sample");
            end
        end

        // R7 write in same cycle as strobe uses old routing
        step(1, 1, 32'h0312_2130, "R7 same-cycle");
        step(1, 0, '0, "R7 next strobe");

        // R5 R6 illegal words
        step(0, 1, 32'h1015_1010, "R5 I too big");
        step(1, 0, '0, "R5 unchanged after I");
        step(0, 1, 32'h1010_7010, "R5 Q gap");
        step(1, 0, '0, "R5 unchanged after Q");
        step(0, 1, 32'h1010_F010, "R5 mixed zero");
        step(1, 0, '0, "R6 sticky");
        step(0, 1, 32'hF3F2_F1F0, "R6 clear legal");
        step(1, 0, '0, "R3 zero mode");

        // R8 second legal write wins
        step(0, 1, 32'h2020_2020, "R8 first");
        step(0, 1, 32'h0313_2231, "R8 second");
        step(1, 0, '0, "R8 apply");

        // R9 reject does not cancel pending
        step(0, 1, 32'h3210_0123, "R9 legal");
        step(0, 1, 32'h0000_00F0, "R9 reject");
        step(1, 0, '0, "R9 apply");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule